// File: doc/BRIEF.md
# PSRAM Burst Fragmenter

This block sits in front of a quad-SPI PSRAM sequencer. It takes one burst request, made of a start address, a byte count, a direction flag and a 32-bit bank descriptor. It breaks the request into device accesses. Each access is offered on a valid/ready command port as an address and a length. The block then waits for a one-cycle completion pulse from the sequencer before it offers the next access.

Each access ends at the first of four limits: the next 1 KB page boundary, the end of the configured device, the burst cap in the descriptor, or the end of the request. Addresses only move upward. They wrap to zero through a mask built from the descriptor's size field.

Pin sequencing, data movement and chip-select choice stay with the sequencer.

Top module: `psram_burst_fragmenter`

## Requirements
- R1: No issued access crosses a 1 KB page boundary: (cmdAddr mod 1024) + cmdLen never exceeds 1024.
- R2: Each access length is the smallest of four values: the bytes still owed, the bytes left in the current page, the bytes left before the device end, and the burst cap. It is never zero.
- R3: The burst cap is descriptor bits 31:16. A cap of zero means the length is limited only by the page, the device end and the remaining count.
- R4: Descriptor bits 4:0 hold the number of significant address bits minus one (S), so the device spans 2^(S+1) bytes. The start address and every later address are reduced modulo that size, and an access that reaches the device end is followed by one at address 0.
- R5: Accesses are issued in ascending order. Each address is the previous address plus the previous length, modulo the device size. The lengths add up to the requested count.
- R6: cmdValid, cmdAddr and cmdLen hold steady until cmdReady is seen. After a handshake, no further access is offered until fragDone pulses.
- R7: busy rises in the cycle after a nonzero request is accepted and falls in the cycle after the last access's fragDone. In that same cycle reqDone pulses high for one cycle.
- R8: A reqValid seen while busy is high is ignored: the running sequence continues unchanged, and no extra access follows.
- R9: A request with a count of zero produces a reqDone pulse in the next cycle. No access is issued and busy stays low.
- R10: cmdWrite carries the accepted request's direction on every one of its accesses.
- R11: After reset, busy, reqDone and cmdValid are low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Request strobe, sampled while idle |
| reqAddr | input | ADDR_W | Request start address |
| reqCount | input | CNT_W | Request byte count |
| reqWrite | input | 1 | Request direction, 1 = write |
| reqDesc | input | 32 | Bank descriptor: [31:16] burst cap, [4:0] size field |
| busy | output | 1 | A request is in progress |
| reqDone | output | 1 | One-cycle pulse when a request completes |
| cmdValid | output | 1 | An access is offered |
| cmdReady | input | 1 | The sequencer takes the offered access |
| cmdAddr | output | ADDR_W | Access start address |
| cmdLen | output | CNT_W | Access length in bytes |
| cmdWrite | output | 1 | Access direction |
| fragDone | input | 1 | The sequencer has finished the current access |

## Verification
The hardest case to reach is an access that the device end and a page end both truncate, then wraps to address 0, while the burst cap and the remaining count are also close to binding. The bench reaches it by sweeping several device sizes, including one of exactly one page. It pairs these with start addresses just below the device end and a page end, burst caps from one byte to above a page, plus zero, and counts that run past the device end. It also varies the handshake delays and injects a stray request during every first access.

// File: rtl/frag_pkg.sv
package frag_pkg;

  // Strobes from control to datapath
  typedef struct packed {
    logic load;     // capture a new request
    logic advance;  // step past the finished access
  } fragCtrl_t;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_ISSUE = 2'd1,
    ST_WAIT  = 2'd2
  } fragState_e;

  localparam int DESC_CAP_LSB = 16;
  localparam int DESC_CAP_W   = 16;

endpackage

// File: rtl/frag_mask.sv
module frag_mask #(
  parameter int ADDR_W = 24,
  parameter int SIZE_W = 5
) (
  input  logic [SIZE_W-1:0] sizeField,
  output logic [ADDR_W-1:0] mask
);
  localparam int SW = SIZE_W + 1;

  logic [SW-1:0] sigBits;
  assign sigBits = SW'(sizeField) + SW'(1);

  // Bit i is set when it lies below the number of significant bits
  for (genvar i = 0; i < ADDR_W; i++) begin : g_bit
    assign mask[i] = (SW'(i) < sigBits);
  end
endmodule

// File: rtl/frag_datapath.sv
module frag_datapath
  import frag_pkg::*;
#(
  parameter int ADDR_W    = 24,
  parameter int CNT_W     = 16,
  parameter int PAGE_BITS = 10,
  parameter int SIZE_W    = 5
) (
  input  logic              clk,
  input  logic              rstN,
  input  fragCtrl_t         ctrl,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [CNT_W-1:0]  reqCount,
  input  logic              reqWrite,
  input  logic [31:0]       reqDesc,
  output logic [ADDR_W-1:0] fragAddr,
  output logic [CNT_W-1:0]  fragLen,
  output logic              fragWrite,
  output logic              lastFrag,
  output logic              countZero
);
  localparam int WIDE       = ((ADDR_W > CNT_W) ? ADDR_W : CNT_W) + 2;
  localparam int PAGE_BYTES = 1 << PAGE_BITS;

  logic [ADDR_W-1:0]     curAddr;
  logic [CNT_W-1:0]      remaining;
  logic                  writeReg;
  logic [SIZE_W-1:0]     sizeReg;
  logic [DESC_CAP_W-1:0] capReg;
  logic [ADDR_W-1:0]     maskIn;
  logic [ADDR_W-1:0]     curMask;

  frag_mask #(.ADDR_W(ADDR_W), .SIZE_W(SIZE_W)) u_maskIn (
    .sizeField(reqDesc[SIZE_W-1:0]),
    .mask     (maskIn)
  );

  frag_mask #(.ADDR_W(ADDR_W), .SIZE_W(SIZE_W)) u_maskCur (
    .sizeField(sizeReg),
    .mask     (curMask)
  );

  // Candidate limits, all in a common wide width
  logic [WIDE-1:0] pageLeft, devLeft, capLen, remWide, minLen;

  always_comb begin
    pageLeft = WIDE'(PAGE_BYTES) - WIDE'(curAddr[PAGE_BITS-1:0]);
    devLeft  = WIDE'(curMask) - WIDE'(curAddr) + WIDE'(1);
    capLen   = (capReg == '0) ? {WIDE{1'b1}} : WIDE'(capReg);
    remWide  = WIDE'(remaining);
    minLen   = remWide;
    if (pageLeft < minLen) minLen = pageLeft;
    if (devLeft  < minLen) minLen = devLeft;
    if (capLen   < minLen) minLen = capLen;
  end

  assign fragLen   = CNT_W'(minLen);
  assign fragAddr  = curAddr;
  assign fragWrite = writeReg;
  assign lastFrag  = (remaining == fragLen);
  assign countZero = (reqCount == '0);

  logic [WIDE-1:0] nextSum;
  assign nextSum = WIDE'(curAddr) + WIDE'(fragLen);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      curAddr   <= '0;
      remaining <= '0;
      writeReg  <= 1'b0;
      sizeReg   <= '0;
      capReg    <= '0;
    end else if (ctrl.load) begin
      curAddr   <= reqAddr & maskIn;
      remaining <= reqCount;
      writeReg  <= reqWrite;
      sizeReg   <= reqDesc[SIZE_W-1:0];
      capReg    <= reqDesc[DESC_CAP_LSB +: DESC_CAP_W];
    end else if (ctrl.advance) begin
      curAddr   <= ADDR_W'(nextSum) & curMask;
      remaining <= remaining - fragLen;
    end
  end

  // R1: an access never spills into the next page
  p_page_r1: assert property (@(posedge clk) disable iff (!rstN)
    (remaining != '0) |->
      (WIDE'(curAddr[PAGE_BITS-1:0]) + WIDE'(fragLen) <= WIDE'(PAGE_BYTES)));

  // R2: pending work always yields a nonzero length within the remaining count
  p_len_nz_r2: assert property (@(posedge clk) disable iff (!rstN)
    (remaining != '0) |-> (fragLen != '0 && fragLen <= remaining));

  // R3: a nonzero cap bounds every length
  p_cap_r3: assert property (@(posedge clk) disable iff (!rstN)
    (remaining != '0 && capReg != '0) |-> (WIDE'(fragLen) <= WIDE'(capReg)));

  // R4: reaching the device end continues at address zero
  p_wrap_r4: assert property (@(posedge clk) disable iff (!rstN)
    (ctrl.advance && nextSum == WIDE'(curMask) + WIDE'(1)) |=> (curAddr == '0));
endmodule

// File: rtl/frag_control.sv
module frag_control
  import frag_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      reqValid,
  input  logic      countZero,
  input  logic      lastFrag,
  input  logic      cmdReady,
  input  logic      fragDone,
  output fragCtrl_t ctrl,
  output logic      cmdValid,
  output logic      busy,
  output logic      reqDone
);
  fragState_e state;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      reqDone <= 1'b0;
    end else begin
      reqDone <= 1'b0;
      unique case (state)
        ST_IDLE: begin
          if (reqValid) begin
            if (countZero) reqDone <= 1'b1;
            else           state   <= ST_ISSUE;
          end
        end
        ST_ISSUE: begin
          if (cmdReady) state <= ST_WAIT;
        end
        ST_WAIT: begin
          if (fragDone) begin
            if (lastFrag) begin
              state   <= ST_IDLE;
              reqDone <= 1'b1;
            end else begin
              state <= ST_ISSUE;
            end
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    ctrl.load    = (state == ST_IDLE) && reqValid && !countZero;
    ctrl.advance = (state == ST_WAIT) && fragDone;
  end

  assign cmdValid = (state == ST_ISSUE);
  assign busy     = (state != ST_IDLE);

  // R6: an offer is withdrawn only through a handshake
  p_hold_r6: assert property (@(posedge clk) disable iff (!rstN)
    (cmdValid && !cmdReady) |=> cmdValid);

  // R6: after a handshake nothing is offered until the access finishes
  p_wait_r6: assert property (@(posedge clk) disable iff (!rstN)
    (cmdValid && cmdReady) |=> !cmdValid);

  // R7: completion coincides with the idle state
  p_done_idle_r7: assert property (@(posedge clk) disable iff (!rstN)
    reqDone |-> !busy);

  // R9: an empty request finishes at once without becoming busy
  p_zero_r9: assert property (@(posedge clk) disable iff (!rstN)
    (!busy && reqValid && countZero) |=> (reqDone && !busy));

  // R8: a request arriving while busy starts nothing new
  p_ignore_r8: assert property (@(posedge clk) disable iff (!rstN)
    (busy && !(state == ST_WAIT && fragDone && lastFrag)) |=> busy);
endmodule

// File: rtl/psram_burst_fragmenter.sv
module psram_burst_fragmenter
  import frag_pkg::*;
#(
  parameter int ADDR_W    = 24,
  parameter int CNT_W     = 16,
  parameter int PAGE_BITS = 10,
  parameter int SIZE_W    = 5
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [CNT_W-1:0]  reqCount,
  input  logic              reqWrite,
  input  logic [31:0]       reqDesc,
  output logic              busy,
  output logic              reqDone,
  output logic              cmdValid,
  input  logic              cmdReady,
  output logic [ADDR_W-1:0] cmdAddr,
  output logic [CNT_W-1:0]  cmdLen,
  output logic              cmdWrite,
  input  logic              fragDone
);
  fragCtrl_t ctrl;
  logic      lastFrag;
  logic      countZero;

  frag_control u_control (
    .clk      (clk),
    .rstN     (rstN),
    .reqValid (reqValid),
    .countZero(countZero),
    .lastFrag (lastFrag),
    .cmdReady (cmdReady),
    .fragDone (fragDone),
    .ctrl     (ctrl),
    .cmdValid (cmdValid),
    .busy     (busy),
    .reqDone  (reqDone)
  );

  frag_datapath #(
    .ADDR_W(ADDR_W), .CNT_W(CNT_W), .PAGE_BITS(PAGE_BITS), .SIZE_W(SIZE_W)
  ) u_datapath (
    .clk      (clk),
    .rstN     (rstN),
    .ctrl     (ctrl),
    .reqAddr  (reqAddr),
    .reqCount (reqCount),
    .reqWrite (reqWrite),
    .reqDesc  (reqDesc),
    .fragAddr (cmdAddr),
    .fragLen  (cmdLen),
    .fragWrite(cmdWrite),
    .lastFrag (lastFrag),
    .countZero(countZero)
  );

  // R6: the offered command is frozen while it waits for the sequencer
  p_stable_r6: assert property (@(posedge clk) disable iff (!rstN)
    (cmdValid && !cmdReady) |=>
      ($stable(cmdAddr) && $stable(cmdLen) && $stable(cmdWrite)));

  // R11: nothing is offered while idle
  p_idle_quiet_r11: assert property (@(posedge clk) disable iff (!rstN)
    !busy |-> !cmdValid);
endmodule

// File: tb/tb_psram_burst_fragmenter.sv
module tb_psram_burst_fragmenter;
  localparam int CLK_PERIOD = 10;
  localparam int ADDR_W     = 24;
  localparam int CNT_W      = 16;

  logic              clk = 1'b0;
  logic              rstN = 1'b0;
  logic              reqValid = 1'b0;
  logic [ADDR_W-1:0] reqAddr = '0;
  logic [CNT_W-1:0]  reqCount = '0;
  logic              reqWrite = 1'b0;
  logic [31:0]       reqDesc = '0;
  logic              busy, reqDone, cmdValid, cmdWrite;
  logic              cmdReady = 1'b0;
  logic              fragDone = 1'b0;
  logic [ADDR_W-1:0] cmdAddr;
  logic [CNT_W-1:0]  cmdLen;

  int tests = 0;
  int fails = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  psram_burst_fragmenter #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) dut (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqAddr(reqAddr),
    .reqCount(reqCount), .reqWrite(reqWrite), .reqDesc(reqDesc),
    .busy(busy), .reqDone(reqDone), .cmdValid(cmdValid), .cmdReady(cmdReady),
    .cmdAddr(cmdAddr), .cmdLen(cmdLen), .cmdWrite(cmdWrite), .fragDone(fragDone)
  );

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  // One request; expected accesses are derived from the requirement arithmetic
  task automatic runReq(input longint a, input longint cnt, input bit wr,
                        input int sz, input longint cap, input int seed);
    longint mask, ea, rem, len, pageLeft, devLeft;
    bit first;
    mask = (sz + 1 >= ADDR_W) ? ((64'd1 << ADDR_W) - 1) : ((64'd1 << (sz + 1)) - 1);
    @(negedge clk);
    reqValid = 1'b1;
    reqAddr  = ADDR_W'(a);
    reqCount = CNT_W'(cnt);
    reqWrite = wr;
    reqDesc  = {16'(cap), 11'd0, 5'(sz)};
    @(negedge clk);
    reqValid = 1'b0;
    if (cnt == 0) begin
      check(reqDone && !busy && !cmdValid, "R9 zero-count done", {reqDone, busy, cmdValid}, 3'b100);
      @(negedge clk);
      check(!reqDone && !cmdValid, "R9 no access after zero count", {reqDone, cmdValid}, 0);
      return;
    end
    check(busy == 1'b1, "R7 busy after accept", busy, 1);
    ea = a & mask;
    rem = cnt;
    first = 1'b1;
    while (rem > 0) begin
      pageLeft = 1024 - (ea % 1024);
      devLeft  = mask + 1 - ea;
      len = rem;
      if (pageLeft < len) len = pageLeft;
      if (devLeft < len) len = devLeft;
      if (cap != 0 && cap < len) len = cap;
      check(cmdValid, "R6 access offered", cmdValid, 1);
      check(cmdAddr == ADDR_W'(ea), "R4/R5 access address", cmdAddr, ea);
      check(cmdLen == CNT_W'(len), "R1/R2/R3 access length", cmdLen, len);
      check(cmdWrite == wr, "R10 access direction", cmdWrite, wr);
      for (int k = 0; k < seed % 3; k++) begin
        @(negedge clk);
        check(cmdValid && cmdAddr == ADDR_W'(ea) && cmdLen == CNT_W'(len),
              "R6 offer held", cmdAddr, ea);
      end
      cmdReady = 1'b1;
      @(negedge clk);
      cmdReady = 1'b0;
      check(!cmdValid, "R6 no offer before done", cmdValid, 0);
      if (first) begin
        reqValid = 1'b1;
        reqAddr  = ~ADDR_W'(a);
        reqCount = CNT_W'(7);
        reqWrite = ~wr;
        reqDesc  = 32'h0003_0017;
      end
      @(negedge clk);
      reqValid = 1'b0;
      check(busy && !cmdValid, "R8 busy and quiet while waiting", {busy, cmdValid}, 2'b10);
      for (int k = 0; k < seed % 2; k++) begin
        @(negedge clk);
        check(!cmdValid, "R6 no offer before done", cmdValid, 0);
      end
      fragDone = 1'b1;
      @(negedge clk);
      fragDone = 1'b0;
      ea = (ea + len) & mask;
      rem = rem - len;
      first = 1'b0;
    end
    check(reqDone && !busy && !cmdValid, "R7 completion", {reqDone, busy, cmdValid}, 3'b100);
    @(negedge clk);
    check(!reqDone && !cmdValid && !busy, "R7/R8 single done, nothing extra",
          {reqDone, cmdValid, busy}, 0);
  endtask

  initial begin
    #(CLK_PERIOD * 190000);
    fails++;
    $display("FAIL watchdog expired");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    int sizes[4]  = '{9, 11, 12, 23};
    int caps[6]   = '{0, 1, 100, 256, 1024, 3000};
    int counts[5] = '{1, 24, 1024, 1500, 5000};
    int seed = 0;
    longint mask, c;
    longint addrs[6];
    repeat (3) @(negedge clk);
    check(!busy && !reqDone && !cmdValid, "R11 reset state", {busy, reqDone, cmdValid}, 0);
    rstN = 1'b1;
    @(negedge clk);
    check(!busy && !reqDone && !cmdValid, "R11 idle after reset", {busy, reqDone, cmdValid}, 0);

    runReq(64'h123, 0, 1'b0, 11, 0, 0);  // R9
    runReq(64'h400, 0, 1'b1, 23, 5, 1);  // R9

    foreach (sizes[si]) begin
      mask = (64'd1 << (sizes[si] + 1)) - 1;
      addrs = '{0, 1, 512, 1023, mask - 5, mask + 1 + 1000};
      foreach (caps[ci]) begin
        foreach (addrs[ai]) begin
          foreach (counts[ni]) begin
            c = counts[ni];
            if (caps[ci] == 1 && c > 40) c = 40;
            runReq(addrs[ai], c, seed[0], sizes[si], caps[ci], seed);
            seed++;
          end
        end
      end
    end

    // R4: a wrap that lands exactly on the device end, then continues from zero
    runReq(64'h7FF000, 64'h2000, 1'b1, 22, 0, 5);
    // R3: maximum cap value with a full-range device
    runReq(64'hFFFFF0, 64'h0800, 1'b0, 23, 65535, 2);

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule